// File: doc/BRIEF.md
# Single-Wire Bus Byte Sequencer with One-Shot Strong Pull-Up

This block sits between a controller that thinks in bytes and a bit-slot generator that produces the timed low pulses of a single-wire open-drain bus. It takes one byte command at a time and expands it into eight slot requests, least-significant bit first. There are three commands. A write sends each data bit. A read requests eight read slots and assembles the sampled levels into a byte. A touch sends each data bit and, in the same slots, captures what the bus returned.

Some bus devices draw extra current right after a write, so a strong pull-up request can be armed ahead of time with a duration in milliseconds. The next write or touch consumes the request. If pull-up hardware is present, the drive output goes high for the last bit slot and stays high for the armed duration after that slot. If no such hardware is present, the engine waits for the same time without driving anything. The millisecond time base counts a microsecond tick shared with the slot generator.

Top module: `ow_byte_engine`

## Requirements
- R1: After reset, slot_req, spu_en and done are low and result is 0x00.
- R2: Opcode 2'b00 (write) issues eight slots whose slot_bit is data bit 0 first through bit 7 last; its result is 0x00.
- R3: Opcode 2'b01 (read) issues eight slots with slot_bit high; result bit i is the slot_sample returned with the i-th acknowledge.
- R4: Opcode 2'b10 (touch) issues slot_bit equal to data bit i in slot i; result bit i is the sample of slot i when that data bit is 1 and 0 when it is 0.
- R5: slot_req stays high, with slot_bit stable, until slot_ack; each acknowledge completes one slot; exactly eight slots are requested per command.
- R6: A command strobe while a byte is in progress is ignored, and opcode 2'b11 is ignored at all times.
- R7: A pull-up request while idle replaces the pending duration, and a duration of 0 cancels it; a request while busy has no effect.
- R8: With a non-zero pending duration D, pull-up support high and a write or touch, spu_en rises in the cycle after the seventh acknowledge. It stays high for D*US_PER_MS microsecond ticks after the eighth acknowledge and falls in the cycle done pulses.
- R9: With pull-up support low, the same write or touch waits D*US_PER_MS microsecond ticks after the last acknowledge with spu_en low, then signals done.
- R10: A write or touch that uses the pending duration clears it; a read neither uses nor clears it.
- R11: done is a one-cycle pulse in the cycle after the last acknowledge when no wait applies, or at the end of the wait; result holds its value until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 write, 01 read, 10 touch, 11 ignored |
| cmd_data | input | 8 | Byte to send |
| result | output | 8 | Collected byte |
| done | output | 1 | Command complete pulse |
| spu_req | input | 1 | Pull-up request strobe |
| spu_ms | input | MS_W | Pull-up duration in milliseconds, 0 cancels |
| spu_support | input | 1 | Strong pull-up hardware present |
| spu_en | output | 1 | Strong pull-up drive |
| slot_req | output | 1 | Slot request to the bit generator |
| slot_bit | output | 1 | 0 requests a write-0 slot, 1 a read/write-1 slot |
| slot_ack | input | 1 | Slot finished |
| slot_sample | input | 1 | Bus level sampled in the finished slot |

## Verification
On every cycle, the embedded properties check the slot handshake hold, the single-cycle done pulse, and the rule that the pull-up drive falls together with done. They also check that the drive rises only during a requested slot and only with pull-up support present. The bench scenarios cover what needs knowledge of the whole command. That includes the least-significant-first bit order, the assembled result bytes, and the exact wait length in ticks. It also includes one-shot consumption, cancellation, the read path keeping the request pending, and stimulus ignored while busy.

// File: rtl/ow_byte_engine.sv
module ow_byte_engine #(
  parameter int MS_W      = 8,
  parameter int US_PER_MS = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            us_tick,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [7:0]      cmd_data,
  output logic [7:0]      result,
  output logic            done,
  input  logic            spu_req,
  input  logic [MS_W-1:0] spu_ms,
  input  logic            spu_support,
  output logic            spu_en,
  output logic            slot_req,
  output logic            slot_bit,
  input  logic            slot_ack,
  input  logic            slot_sample
);

  localparam int US_W = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
  localparam logic [1:0] OP_WR  = 2'b00;
  localparam logic [1:0] OP_RD  = 2'b01;
  localparam logic [1:0] OP_BAD = 2'b11;
  localparam logic [US_W-1:0] US_LAST = US_W'(US_PER_MS - 1);

  typedef enum logic [1:0] {S_IDLE, S_SLOT, S_HOLD} st_t;

  st_t             st;
  logic [1:0]      op;
  logic [7:0]      data;
  logic [2:0]      idx;
  logic [MS_W-1:0] pend;
  logic [MS_W-1:0] hold_ms;
  logic [US_W-1:0] us_cnt;

  wire idle    = (st == S_IDLE);
  wire is_read = (op == OP_RD);
  wire pu_use  = !is_read && (pend != '0);
  wire ms_edge = us_tick && (us_cnt == US_LAST);

  assign slot_req = (st == S_SLOT);
  assign slot_bit = is_read | data[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op      <= OP_WR;
      data    <= '0;
      idx     <= '0;
      pend    <= '0;
      hold_ms <= '0;
      us_cnt  <= '0;
      result  <= '0;
      done    <= 1'b0;
      spu_en  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (idle && spu_req) pend <= spu_ms;
      case (st)
        S_IDLE: begin
          if (cmd_valid && cmd_op != OP_BAD) begin
            op     <= cmd_op;
            data   <= cmd_data;
            idx    <= '0;
            result <= '0;
            st     <= S_SLOT;
          end
        end
        S_SLOT: begin
          if (slot_ack) begin
            result[idx] <= (op != OP_WR) & slot_bit & slot_sample;
            if (idx == 3'd7) begin
              if (pu_use) begin
                hold_ms <= pend;
                pend    <= '0;
                us_cnt  <= '0;
                st      <= S_HOLD;
              end else begin
                st   <= S_IDLE;
                done <= 1'b1;
              end
            end else begin
              idx <= idx + 3'd1;
              if (idx == 3'd6 && pu_use && spu_support) spu_en <= 1'b1;
            end
          end
        end
        S_HOLD: begin
          if (us_tick) begin
            if (ms_edge) begin
              us_cnt <= '0;
              if (hold_ms == MS_W'(1)) begin
                st     <= S_IDLE;
                done   <= 1'b1;
                spu_en <= 1'b0;
              end else begin
                hold_ms <= hold_ms - MS_W'(1);
              end
            end else begin
              us_cnt <= us_cnt + US_W'(1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && !slot_ack |=> slot_req && $stable(slot_bit));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  spu_off_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !spu_en);

  // R8
  spu_rise_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spu_en) |-> slot_req);

  // R9
  spu_needs_support_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spu_en) |-> spu_support);

  // R5
  no_slot_while_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !slot_req);

endmodule

// File: tb/ow_byte_engine_tb_top.sv
module ow_byte_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MS_W = 8;
  localparam int USMS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic [7:0] result;
  logic done;
  logic spu_req = 1'b0;
  logic [MS_W-1:0] spu_ms = '0;
  logic spu_support = 1'b0;
  logic spu_en, slot_req, slot_bit;
  logic slot_ack = 1'b0;
  logic slot_sample = 1'b0;

  int total = 0;
  int bad = 0;
  int pend_model = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ow_byte_engine #(.MS_W(MS_W), .US_PER_MS(USMS)) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .result(result), .done(done),
    .spu_req(spu_req), .spu_ms(spu_ms), .spu_support(spu_support),
    .spu_en(spu_en), .slot_req(slot_req), .slot_bit(slot_bit),
    .slot_ack(slot_ack), .slot_sample(slot_sample));

  function automatic void chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endfunction

  task automatic arm_pullup(int ms);
    @(negedge clk);
    spu_req = 1'b1;
    spu_ms  = MS_W'(ms);
    @(negedge clk);
    spu_req = 1'b0;
    pend_model = ms;
  endtask

  task automatic run_byte(bit [1:0] op, bit [7:0] d, bit [7:0] smp,
                          int lat, bit sup, bit poke);
    bit exp_pu, exp_drv;
    bit [7:0] exp_res;
    int n;
    spu_support = sup;
    exp_pu  = (op != 2'b01) && (pend_model != 0);
    exp_drv = exp_pu && sup;
    exp_res = (op == 2'b00) ? 8'h00 : (op == 2'b01) ? smp : (smp & d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk(slot_req == 1'b1, "R5 slot_req", int'(slot_req), 1);
      chk(slot_bit == ((op == 2'b01) ? 1'b1 : d[i]), "R2/R3/R4 slot_bit order",
          int'(slot_bit), int'((op == 2'b01) ? 1'b1 : d[i]));
      chk(spu_en == (i == 7 && exp_drv), "R8 spu_en during slot",
          int'(spu_en), int'(i == 7 && exp_drv));
      chk(done == 1'b0, "R11 no early done", int'(done), 0);
      for (int k = 0; k < lat; k++) begin
        if (poke && i == 3 && k == 0) begin
          cmd_valid = 1'b1; cmd_op = 2'b01; cmd_data = ~d;
          spu_req = 1'b1; spu_ms = MS_W'(9);
        end
        @(negedge clk);
        cmd_valid = 1'b0; spu_req = 1'b0;
        chk(slot_req == 1'b1, "R5 slot_req held", int'(slot_req), 1);
      end
      slot_ack = 1'b1; slot_sample = smp[i];
      @(negedge clk);
      slot_ack = 1'b0;
    end
    n = 0;
    while (!done && n < 10000) begin
      chk(spu_en == exp_drv, "R8/R9 spu_en in wait", int'(spu_en), int'(exp_drv));
      chk(slot_req == 1'b0, "R5 no extra slot", int'(slot_req), 0);
      @(negedge clk);
      n++;
    end
    chk(n == (exp_pu ? pend_model * USMS : 0), "R8/R9/R11 wait length", n,
        exp_pu ? pend_model * USMS : 0);
    chk(result == exp_res, "R2/R3/R4 result", int'(result), int'(exp_res));
    chk(spu_en == 1'b0, "R8 spu_en off at done", int'(spu_en), 0);
    if (exp_pu) pend_model = 0;
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", int'(done), 0);
    chk(slot_req == 1'b0, "R5 eight slots only", int'(slot_req), 0);
    repeat (2) @(negedge clk);
    chk(result == exp_res, "R11 result held", int'(result), int'(exp_res));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(slot_req == 1'b0, "R1 slot_req", int'(slot_req), 0);
    chk(spu_en == 1'b0, "R1 spu_en", int'(spu_en), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(result == 8'h00, "R1 result", int'(result), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_byte(2'b00, 8'hA5, 8'hFF, 2, 1'b0, 1'b0);
    run_byte(2'b01, 8'h00, 8'h3C, 0, 1'b0, 1'b0);
    run_byte(2'b10, 8'hF0, 8'hFF, 1, 1'b0, 1'b0);
    run_byte(2'b10, 8'h5A, 8'h33, 3, 1'b0, 1'b0);

    // R6: opcode 11 is ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11; cmd_data = 8'h55;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) begin
      chk(slot_req == 1'b0, "R6 bad opcode ignored", int'(slot_req), 0);
      @(negedge clk);
    end

    // R10: read keeps the request, write consumes it (R8)
    arm_pullup(2);
    run_byte(2'b01, 8'h00, 8'hC3, 1, 1'b1, 1'b0);
    run_byte(2'b00, 8'h81, 8'h00, 1, 1'b1, 1'b0);
    run_byte(2'b00, 8'h7E, 8'h00, 0, 1'b1, 1'b0);

    // R9: no pull-up hardware, timed wait only
    arm_pullup(3);
    run_byte(2'b00, 8'h3C, 8'h00, 2, 1'b0, 1'b0);

    // R7: zero cancels
    arm_pullup(2);
    arm_pullup(0);
    run_byte(2'b00, 8'hC6, 8'h00, 1, 1'b1, 1'b0);

    // R6 and R7: stimulus while busy ignored, then one-shot used by touch
    arm_pullup(1);
    run_byte(2'b10, 8'h96, 8'hF0, 2, 1'b1, 1'b1);
    run_byte(2'b00, 8'h0F, 8'h00, 1, 1'b1, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule